// File: doc/BRIEF.md
# Data Window Address Translator

This block turns a 16-bit logical data address into a location in one of three physical memory spaces: unified memory, instruction memory or internal data memory. The logical space is cut into equal windows. Each window has its own programmable 16-bit map word, and that word decides where the window lands. A map word can also put its window into an I/O mode. In that mode the window is split into four sub-pages, and a separate 4-bit page number for each sub-page is taken from a nibble of the map word.

Requests carry a logical offset and a byte count and enter through a valid/ready handshake. One cycle after a request is accepted, the response presents the target space (as an enumeration, not as a base address added in), the address within that space, the byte count clipped so that the access does not run past the end of its window, and an error flag. The map words are loaded through a simple write port that decodes data-space addresses. A request accepted in the same cycle as a map write is translated with the map value from before the write.

Top module: `dwt_translator`

## Requirements
- R1: After reset, windows 0, 1 and 2 hold map 0x2000 (internal data, segment 0) and window 3 holds 0x0000 (unified, segment 0). After reset rsp_valid is 0 and req_ready is 1.
- R2: The window index is the logical offset divided by BLK_SIZE, and the offset within the window is the remainder. The map word of that window is the one used.
- R3: A logical offset at or above BLK_SIZE × NUM_MAPS returns rsp_err=1, rsp_cnt=0, rsp_phys=0 and rsp_space=3.
- R4: When the in-window offset plus the byte count exceeds BLK_SIZE, rsp_cnt is BLK_SIZE minus the in-window offset. Otherwise rsp_cnt equals the request count.
- R5: The space selector is map bits 13:12. Value 00 gives rsp_space=0 (unified) and 01 gives rsp_space=1 (instruction). For both, rsp_phys = segment × BLK_SIZE + in-window offset, where the segment is map bits 9:0.
- R6: Selector 10 gives rsp_space=2 (internal data) with rsp_phys = (segment << 16) + window index × BLK_SIZE + in-window offset.
- R7: Selector 11 with map bit 15 clear is reserved. It returns rsp_err=1, rsp_cnt=0, rsp_phys=0 and rsp_space=3.
- R8: Map bit 15 set selects I/O mode and overrides the selector. The sub-page is (in-window offset / 0x1000) mod 4. The page is map nibble (3 − sub-page), where nibble k is bits 4k+3:4k. The result is rsp_space=2, rsp_phys = page × 0x10000 + 0xC000 + in-window offset, and no error.
- R9: A write with map_we=1 to address 0xFF08 + 2n loads map n, and a write to 0xFF04 loads map 2. Writes to any other address, odd addresses included, change no map.
- R10: rsp_valid rises in the cycle after a request is accepted. While rsp_valid=1 and rsp_ready=0, the response holds steady and req_ready=0. req_ready = !rsp_valid || rsp_ready.
- R11: A request accepted in the same cycle as a map write is translated with the map value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_we | input | 1 | Map write strobe |
| map_addr | input | 16 | Data address of the map write |
| map_wdata | input | 16 | Map word to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_off | input | 16 | Logical data offset |
| req_cnt | input | 16 | Requested byte count |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle |
| rsp_space | output | 2 | Target space: 0 unified, 1 instruction, 2 internal data, 3 none |
| rsp_phys | output | 26 | Address within the target space |
| rsp_cnt | output | 16 | Clipped byte count |
| rsp_err | output | 1 | Unsupported offset or reserved selector |

## Verification
The bench drives two instances with the same stimulus. The first uses the default window size of 0x4000, which makes the four windows span the whole 16-bit offset range. That instance reaches the I/O sub-page selection across all four nibbles and clipping at the top of the address space. The second uses a window size of 0x1000, so the four windows cover only 0x0000 to 0x3FFF. This is the only way the out-of-range rejection can be reached, and the bench also checks clipping just below that limit.

// File: rtl/dwt_pkg.sv
// Shared types and constants for the data window address translator.
// Assumes 16-bit map words with the I/O flag in bit 15 and the
// space selector in bits 13:12.
package dwt_pkg;

    localparam int MAP_W     = 16;
    localparam int IO_BIT    = 15;
    localparam int SEL_LO    = 12;
    localparam int IO_PAGE_SHIFT = 16;
    localparam int IO_WINDOW_BASE = 'hC000;

    typedef enum logic [1:0] {
        SPC_UNIFIED = 2'b00,
        SPC_INSN    = 2'b01,
        SPC_DATA    = 2'b10,
        SPC_NONE    = 2'b11
    } dwt_space_e;

    // Power-up map word: the last window points at unified memory,
    // all other windows point at internal data segment 0.
    function automatic logic [MAP_W-1:0] map_reset_word(input int idx, input int nmaps);
        return (idx == nmaps - 1) ? 16'h0000 : 16'h2000;
    endfunction

endpackage

// File: rtl/dwt_map_regs.sv
// Map register bank. Holds one map word per window and decodes writes
// from the data address space: slot n at MAP_BASE + 2n, plus one alias
// address that lands on slot ALIAS_IDX. Any other address is ignored.
// Assumes MAP_BASE + 2*NUM_MAPS fits in ADDR_W bits.
module dwt_map_regs
    import dwt_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_MAPS   = 4,
    parameter int MAP_BASE   = 'hFF08,
    parameter int ALIAS_ADDR = 'hFF04,
    parameter int ALIAS_IDX  = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [MAP_W-1:0]                wdata,
    output logic [NUM_MAPS-1:0][MAP_W-1:0]  maps
);

    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADDR  = ADDR_W'(MAP_BASE + 2 * g);
        localparam logic [ADDR_W-1:0] ALIAS_A    = ADDR_W'(ALIAS_ADDR);
        localparam bit                HAS_ALIAS  = (g == ALIAS_IDX);
        localparam logic [MAP_W-1:0]  RST_WORD   = map_reset_word(g, NUM_MAPS);

        logic hit;

        // Address match for this slot, direct or through the alias.
        always_comb begin
            hit = we && ((addr == SLOT_ADDR) || (HAS_ALIAS && (addr == ALIAS_A)));
        end

        // Slot storage with its power-up value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                maps[g] <= RST_WORD;
            end else if (hit) begin
                maps[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/dwt_window_split.sv
// Splits a logical offset into window index and in-window offset,
// flags offsets beyond the last window, and clips the byte count so
// that the access stays inside its window.
// Assumes BLK_SIZE is a power of two and BLK_W + IDX_W <= ADDR_W.
module dwt_window_split #(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 16,
    parameter int BLK_SIZE = 'h4000,
    parameter int NUM_MAPS = 4,
    localparam int BLK_W   = $clog2(BLK_SIZE),
    localparam int IDX_W   = $clog2(NUM_MAPS)
) (
    input  logic [ADDR_W-1:0] off,
    input  logic [CNT_W-1:0]  cnt,
    output logic [IDX_W-1:0]  idx,
    output logic [BLK_W-1:0]  inoff,
    output logic [CNT_W-1:0]  cnt_clip,
    output logic              out_of_range
);

    localparam int SUM_W = ((CNT_W > BLK_W) ? CNT_W : BLK_W) + 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_MAPS * BLK_SIZE);

    logic [SUM_W-1:0] room;

    // Index, remainder and range test.
    always_comb begin
        idx          = IDX_W'(off >> BLK_W);
        inoff        = off[BLK_W-1:0];
        out_of_range = ({1'b0, off} >= LIMIT);
    end

    // Byte count limited to what is left in the window.
    always_comb begin
        room     = SUM_W'(BLK_SIZE) - SUM_W'(inoff);
        cnt_clip = (SUM_W'(cnt) > room) ? CNT_W'(room) : cnt;
    end

endmodule

// File: rtl/dwt_target_calc.sv
// Decodes one map word into target space and address. I/O mode (map
// bit 15) wins over the 2-bit selector; selector 11 is reserved and
// reported as an error, as is an out-of-range offset.
// Assumes PHYS_W >= SEG_W + 16 so no term overflows.
module dwt_target_calc
    import dwt_pkg::*;
#(
    parameter int BLK_W  = 14,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 16,
    parameter int SEG_W  = 10,
    parameter int PHYS_W = 26
) (
    input  logic [MAP_W-1:0]  map,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BLK_W-1:0]  inoff,
    input  logic [CNT_W-1:0]  cnt_clip,
    input  logic              out_of_range,
    output dwt_space_e        space,
    output logic [PHYS_W-1:0] phys,
    output logic [CNT_W-1:0]  cnt,
    output logic              err
);

    logic [SEG_W-1:0]  seg;
    logic [1:0]        sub;
    logic [3:0]        page;
    logic [PHYS_W-1:0] seg_phys;
    logic [PHYS_W-1:0] data_phys;
    logic [PHYS_W-1:0] io_phys;

    // Candidate addresses for each kind of target.
    always_comb begin
        seg       = map[SEG_W-1:0];
        sub       = 2'(32'(inoff) >> 12);
        page      = 4'(map >> {~sub, 2'b00});
        seg_phys  = (PHYS_W'(seg) << BLK_W) + PHYS_W'(inoff);
        data_phys = (PHYS_W'(seg) << IO_PAGE_SHIFT) + (PHYS_W'(idx) << BLK_W) + PHYS_W'(inoff);
        io_phys   = (PHYS_W'(page) << IO_PAGE_SHIFT) + PHYS_W'(IO_WINDOW_BASE) + PHYS_W'(inoff);
    end

    // Pick the target by priority: range, I/O flag, selector.
    always_comb begin
        space = SPC_NONE;
        phys  = '0;
        cnt   = '0;
        err   = 1'b1;
        if (!out_of_range) begin
            if (map[IO_BIT]) begin
                space = SPC_DATA;
                phys  = io_phys;
                cnt   = cnt_clip;
                err   = 1'b0;
            end else begin
                case (map[SEL_LO+1:SEL_LO])
                    2'b00: begin
                        space = SPC_UNIFIED;
                        phys  = seg_phys;
                        cnt   = cnt_clip;
                        err   = 1'b0;
                    end
                    2'b01: begin
                        space = SPC_INSN;
                        phys  = seg_phys;
                        cnt   = cnt_clip;
                        err   = 1'b0;
                    end
                    2'b10: begin
                        space = SPC_DATA;
                        phys  = data_phys;
                        cnt   = cnt_clip;
                        err   = 1'b0;
                    end
                    default: begin
                        space = SPC_NONE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/dwt_translator.sv
// Top of the data window address translator. Map bank, window split
// and target decode are combined in front of a single response
// register with a valid/ready handshake. A request accepted in the
// same cycle as a map write sees the old map word.
// Assumes NUM_MAPS is a power of two of at least 2.
module dwt_translator
    import dwt_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int BLK_SIZE   = 'h4000,
    parameter int NUM_MAPS   = 4,
    parameter int SEG_W      = 10,
    parameter int MAP_BASE   = 'hFF08,
    parameter int ALIAS_ADDR = 'hFF04,
    parameter int ALIAS_IDX  = 2,
    localparam int PHYS_W    = SEG_W + 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_we,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [MAP_W-1:0]  map_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_off,
    input  logic [CNT_W-1:0]  req_cnt,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_space,
    output logic [PHYS_W-1:0] rsp_phys,
    output logic [CNT_W-1:0]  rsp_cnt,
    output logic              rsp_err
);

    localparam int BLK_W = $clog2(BLK_SIZE);
    localparam int IDX_W = $clog2(NUM_MAPS);

    logic [NUM_MAPS-1:0][MAP_W-1:0] maps;
    logic [IDX_W-1:0]  idx;
    logic [BLK_W-1:0]  inoff;
    logic [CNT_W-1:0]  cnt_clip;
    logic              oor;
    logic [MAP_W-1:0]  cur_map;
    dwt_space_e        nx_space;
    logic [PHYS_W-1:0] nx_phys;
    logic [CNT_W-1:0]  nx_cnt;
    logic              nx_err;
    logic              take;

    dwt_map_regs #(
        .ADDR_W(ADDR_W), .NUM_MAPS(NUM_MAPS), .MAP_BASE(MAP_BASE),
        .ALIAS_ADDR(ALIAS_ADDR), .ALIAS_IDX(ALIAS_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(map_we), .addr(map_addr),
        .wdata(map_wdata), .maps(maps)
    );

    dwt_window_split #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_SIZE(BLK_SIZE), .NUM_MAPS(NUM_MAPS)
    ) u_split (
        .off(req_off), .cnt(req_cnt), .idx(idx), .inoff(inoff),
        .cnt_clip(cnt_clip), .out_of_range(oor)
    );

    // Map word of the addressed window.
    always_comb begin
        cur_map = maps[idx];
    end

    dwt_target_calc #(
        .BLK_W(BLK_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEG_W(SEG_W), .PHYS_W(PHYS_W)
    ) u_calc (
        .map(cur_map), .idx(idx), .inoff(inoff), .cnt_clip(cnt_clip),
        .out_of_range(oor), .space(nx_space), .phys(nx_phys),
        .cnt(nx_cnt), .err(nx_err)
    );

    // Handshake: accept when the response slot is free or draining.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        take      = req_valid && req_ready;
    end

    // Response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_space <= SPC_NONE;
            rsp_phys  <= '0;
            rsp_cnt   <= '0;
            rsp_err   <= 1'b0;
        end else if (take) begin
            rsp_valid <= 1'b1;
            rsp_space <= nx_space;
            rsp_phys  <= nx_phys;
            rsp_cnt   <= nx_cnt;
            rsp_err   <= nx_err;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dwt_translator_chk.sv
// Port-level checker for the translator, bound into every instance.
module dwt_translator_chk #(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 16,
    parameter int BLK_SIZE = 'h4000,
    parameter int NUM_MAPS = 4,
    parameter int PHYS_W   = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_off,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [1:0]        rsp_space,
    input logic [PHYS_W-1:0] rsp_phys,
    input logic [CNT_W-1:0]  rsp_cnt,
    input logic              rsp_err
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_MAPS * BLK_SIZE);

    p_range_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ({1'b0, req_off} >= LIMIT)) |=> rsp_err);

    p_err_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_cnt == '0 && rsp_phys == '0));

    p_clip_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_cnt <= CNT_W'(BLK_SIZE)));

    p_err_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err == (rsp_space == 2'b11)));

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_phys) &&
            $stable(rsp_cnt) && $stable(rsp_space) && $stable(rsp_err)));

endmodule

bind dwt_translator dwt_translator_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_SIZE(BLK_SIZE),
    .NUM_MAPS(NUM_MAPS), .PHYS_W(PHYS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_off(req_off), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_space(rsp_space), .rsp_phys(rsp_phys), .rsp_cnt(rsp_cnt),
    .rsp_err(rsp_err)
);

// File: tb/sim_dwt_translator.sv
// Directed bench: u0 uses 0x4000 windows, u1 uses 0x1000 windows.
module sim_dwt_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [15:0] map_addr = '0;
    logic [15:0] map_wdata = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_off = '0;
    logic [15:0] req_cnt = '0;
    logic        rsp_ready = 1'b1;

    logic        req_ready, rsp_valid, rsp_err;
    logic [1:0]  rsp_space;
    logic [25:0] rsp_phys;
    logic [15:0] rsp_cnt;

    logic        u1_req_ready, u1_rsp_valid, u1_rsp_err;
    logic [1:0]  u1_rsp_space;
    logic [25:0] u1_rsp_phys;
    logic [15:0] u1_rsp_cnt;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    dwt_translator u0 (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_addr(map_addr),
        .map_wdata(map_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_off(req_off), .req_cnt(req_cnt), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_space(rsp_space), .rsp_phys(rsp_phys),
        .rsp_cnt(rsp_cnt), .rsp_err(rsp_err)
    );

    dwt_translator #(.BLK_SIZE('h1000)) u1 (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_addr(map_addr),
        .map_wdata(map_wdata), .req_valid(req_valid), .req_ready(u1_req_ready),
        .req_off(req_off), .req_cnt(req_cnt), .rsp_valid(u1_rsp_valid),
        .rsp_ready(rsp_ready), .rsp_space(u1_rsp_space), .rsp_phys(u1_rsp_phys),
        .rsp_cnt(u1_rsp_cnt), .rsp_err(u1_rsp_err)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr_map(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        map_we = 1'b1; map_addr = a; map_wdata = d;
        @(negedge clk);
        map_we = 1'b0;
    endtask

    // One request with rsp_ready high; outputs are sampled a half cycle
    // after the accepting edge.
    task automatic send(input logic [15:0] o, input logic [15:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_off = o; req_cnt = c;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_u0(input string tag, input logic [1:0] sp, input logic [25:0] ph,
                             input logic [15:0] ct, input logic er);
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " space"}, 32'(rsp_space), 32'(sp));
        check({tag, " phys"},  32'(rsp_phys),  32'(ph));
        check({tag, " cnt"},   32'(rsp_cnt),   32'(ct));
        check({tag, " err"},   32'(rsp_err),   32'(er));
    endtask

    task automatic expect_u1(input string tag, input logic [1:0] sp, input logic [25:0] ph,
                             input logic [15:0] ct, input logic er);
        check({tag, " u1 valid"}, 32'(u1_rsp_valid), 32'd1);
        check({tag, " u1 space"}, 32'(u1_rsp_space), 32'(sp));
        check({tag, " u1 phys"},  32'(u1_rsp_phys),  32'(ph));
        check({tag, " u1 cnt"},   32'(u1_rsp_cnt),   32'(ct));
        check({tag, " u1 err"},   32'(u1_rsp_err),   32'(er));
    endtask

    task automatic t_reset_state;
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 req_ready after reset", 32'(req_ready), 32'd1);
        send(16'h0010, 16'd4);
        expect_u0("R1 window0 data", 2'd2, 26'h0010, 16'd4, 1'b0);
        send(16'h8004, 16'd2);
        expect_u0("R1 R6 window2 data", 2'd2, 26'h8004, 16'd2, 1'b0);
        send(16'hC020, 16'd2);
        expect_u0("R1 window3 unified", 2'd0, 26'h0020, 16'd2, 1'b0);
    endtask

    task automatic t_write_decode;
        wr_map(16'hFF08, 16'h1005);
        send(16'h0100, 16'd2);
        expect_u0("R9 R5 map0 insn", 2'd1, 26'h14100, 16'd2, 1'b0);
        wr_map(16'hFF04, 16'h0003);
        send(16'h8200, 16'd2);
        expect_u0("R9 alias map2 unified", 2'd0, 26'h0C200, 16'd2, 1'b0);
        wr_map(16'hFF0C, 16'h2001);
        send(16'h8200, 16'd2);
        expect_u0("R9 R2 map2 data", 2'd2, 26'h18200, 16'd2, 1'b0);
        wr_map(16'hFF09, 16'h3000);
        wr_map(16'hFF10, 16'h3000);
        wr_map(16'hFF06, 16'h3000);
        send(16'h0100, 16'd2);
        expect_u0("R9 ignored map0", 2'd1, 26'h14100, 16'd2, 1'b0);
        send(16'h4040, 16'd2);
        expect_u0("R9 R2 ignored map1", 2'd2, 26'h04040, 16'd2, 1'b0);
        send(16'hC020, 16'd2);
        expect_u0("R9 ignored map3", 2'd0, 26'h00020, 16'd2, 1'b0);
    endtask

    task automatic t_spaces;
        wr_map(16'hFF0A, 16'h23FF);
        send(16'h4321, 16'd1);
        expect_u0("R6 data top seg", 2'd2, 26'h3FF4321, 16'd1, 1'b0);
        wr_map(16'hFF0E, 16'h03FF);
        send(16'hFFFE, 16'd2);
        expect_u0("R5 unified top seg", 2'd0, 26'hFFFFFE, 16'd2, 1'b0);
        wr_map(16'hFF08, 16'h1C05);
        send(16'h0000, 16'd2);
        expect_u0("R5 segment bits masked", 2'd1, 26'h14000, 16'd2, 1'b0);
        wr_map(16'hFF08, 16'h3002);
        send(16'h0010, 16'd4);
        expect_u0("R7 reserved selector", 2'd3, 26'h0, 16'd0, 1'b1);
    endtask

    task automatic t_clip;
        wr_map(16'hFF08, 16'h2000);
        send(16'h3FFC, 16'd8);
        expect_u0("R4 clip over end", 2'd2, 26'h3FFC, 16'd4, 1'b0);
        send(16'h3FFC, 16'd4);
        expect_u0("R4 exact fit", 2'd2, 26'h3FFC, 16'd4, 1'b0);
        send(16'h0000, 16'h4000);
        expect_u0("R4 whole window", 2'd2, 26'h0000, 16'h4000, 1'b0);
        send(16'h0001, 16'hFFFF);
        expect_u0("R4 huge count", 2'd2, 26'h0001, 16'h3FFF, 1'b0);
    endtask

    task automatic t_io;
        wr_map(16'hFF0A, 16'hA5C3);
        send(16'h4010, 16'd2);
        expect_u0("R8 sub0 nibble3", 2'd2, 26'hAC010, 16'd2, 1'b0);
        send(16'h5020, 16'd2);
        expect_u0("R8 sub1 nibble2", 2'd2, 26'h5D020, 16'd2, 1'b0);
        send(16'h6030, 16'd2);
        expect_u0("R8 sub2 nibble1", 2'd2, 26'hCE030, 16'd2, 1'b0);
        send(16'h7FFE, 16'd4);
        expect_u0("R8 R4 sub3 nibble0 clipped", 2'd2, 26'h3FFFE, 16'd2, 1'b0);
        wr_map(16'hFF0A, 16'hB000);
        send(16'h4004, 16'd2);
        expect_u0("R8 over reserved selector", 2'd2, 26'hBC004, 16'd2, 1'b0);
    endtask

    task automatic t_range;
        wr_map(16'hFF0E, 16'h0002);
        send(16'h4000, 16'd2);
        expect_u1("R3 first beyond limit", 2'd3, 26'h0, 16'd0, 1'b1);
        expect_u0("R3 in range on large windows", 2'd2, 26'hBC000, 16'd2, 1'b0);
        send(16'hFFFF, 16'd1);
        expect_u1("R3 top offset", 2'd3, 26'h0, 16'd0, 1'b1);
        send(16'h3FFF, 16'd4);
        expect_u1("R3 R4 last byte in range", 2'd0, 26'h2FFF, 16'd1, 1'b0);
    endtask

    task automatic t_write_race;
        @(negedge clk);
        map_we = 1'b1; map_addr = 16'hFF08; map_wdata = 16'h1007;
        req_valid = 1'b1; req_off = 16'h0008; req_cnt = 16'd2;
        @(negedge clk);
        map_we = 1'b0; req_valid = 1'b0;
        expect_u0("R11 old map used", 2'd2, 26'h0008, 16'd2, 1'b0);
        send(16'h0008, 16'd2);
        expect_u0("R11 new map next", 2'd1, 26'h1C008, 16'd2, 1'b0);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_off = 16'h0010; req_cnt = 16'd1;
        @(negedge clk);
        expect_u0("R10 first response", 2'd1, 26'h1C010, 16'd1, 1'b0);
        check("R10 stalled ready", 32'(req_ready), 32'd0);
        req_off = 16'h0020; req_cnt = 16'd3;
        @(negedge clk);
        expect_u0("R10 held response", 2'd1, 26'h1C010, 16'd1, 1'b0);
        check("R10 still stalled", 32'(req_ready), 32'd0);
        rsp_ready = 1'b1;
        #1;
        check("R10 ready follows rsp_ready", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_u0("R10 second response", 2'd1, 26'h1C020, 16'd3, 1'b0);
        @(negedge clk);
        check("R10 drained", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_write_decode();
        t_spaces();
        t_clip();
        t_io();
        t_range();
        t_write_race();
        t_backpressure();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule